// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration and Readback Master

This block is the master side of a byte-wide slave configuration port on a target FPGA. In load mode it clears the target with a program pulse. It then waits for the target to finish clearing its configuration memory and clocks in one byte per rising edge of the configuration clock. The bytes come from a valid/ready stream. When the stream's last byte has gone out, the block releases the port and keeps clocking until the target reports that it is configured.

In readback mode it selects the target with the write strobe low and leaves the shared data bus undriven. It pulses the clock once per byte and samples the bus at the end of each high phase. It delivers a requested number of bytes on a valid-only output stream, then deselects the target and issues one closing clock pulse.

All configuration pins are driven at their logical asserted level, so 1 means asserted. Every clock phase lasts a parameterised number of system clocks. Every wait on the target has a timeout. Each operation ends with a one-cycle completion pulse that carries a status code.

Top module: `pcfg_master`

## Requirements
- R1: After reset, cfg_prog, cfg_sel and cfg_wr are low, cfg_clk is high, and ld_ready, rb_valid, fin, aborted and active are low.
- R2: A load begins with cfg_prog high for exactly PHASE system clocks, and cfg_sel is not asserted while cfg_clearing or cfg_busy is still high.
- R3: If cfg_clearing stays high for TMO_CYCLES clocks after the program pulse, the block pulses aborted and ends with fin_code 1 (init timeout), and cfg_sel is never asserted.
- R4: Each byte accepted on the load stream (ld_valid and ld_ready high at a clock edge) is held on cfg_dq while cfg_sel and cfg_wr are high and gets exactly one rising edge of cfg_clk. Bytes go out in stream order.
- R5: In load mode every low phase of cfg_clk lasts exactly PHASE system clocks.
- R6: With BUSY_CHECK set, when cfg_busy is high at the end of a byte's high phase, the block issues further clock pulses with the same byte on the bus. It asks for no new byte until cfg_busy is low.
- R7: If the extra busy pulses run for TMO_CYCLES clocks, the block pulses aborted and ends with fin_code 2 (busy timeout).
- R8: After the byte marked ld_last, cfg_sel falls first and cfg_wr falls exactly PHASE clocks later.
- R9: After the load, cfg_clk keeps pulsing until cfg_done is seen high, and the number of pulses equals the number the target needed. The block then ends with fin_code 0 and no abort. If cfg_done stays low for TMO_CYCLES clocks, it ends with fin_code 3 (done timeout) and aborted.
- R10: In readback mode cfg_sel is high and cfg_wr is low, the block does not drive cfg_dq, and the k-th rb_valid pulse carries the bus value present after the k-th rising edge of cfg_clk. There are exactly dump_len pulses.
- R11: A readback ends with cfg_sel released and then exactly one rising edge of cfg_clk while deselected, followed by fin_code 0.
- R12: start_load and start_dump are ignored while an operation is active; start_load wins if both are raised together in idle.
- R13: A readback with dump_len 0 produces no rb_valid pulse and still ends with the closing clock pulse and fin_code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_load | input | 1 | Start a configuration load (sampled in idle) |
| start_dump | input | 1 | Start a readback (sampled in idle) |
| dump_len | input | LEN_W | Number of bytes to read back, captured at start |
| ld_data | input | DW | Load stream byte |
| ld_valid | input | 1 | Load stream byte valid |
| ld_last | input | 1 | Marks the final load byte |
| ld_ready | output | 1 | Block accepts a load byte |
| rb_data | output | DW | Readback byte |
| rb_valid | output | 1 | One-cycle readback byte strobe |
| cfg_prog | output | 1 | Program (clear) request to the target |
| cfg_sel | output | 1 | Target chip select |
| cfg_wr | output | 1 | Write strobe (high for load, low for readback) |
| cfg_clk | output | 1 | Configuration clock |
| cfg_dq | inout | DW | Shared configuration data bus |
| cfg_clearing | input | 1 | Target still clearing its configuration memory |
| cfg_busy | input | 1 | Target cannot take the current byte |
| cfg_done | input | 1 | Target configuration complete |
| active | output | 1 | An operation is in progress |
| fin | output | 1 | One-cycle completion pulse |
| fin_code | output | 2 | Status with fin: 0 ok, 1 init timeout, 2 busy timeout, 3 done timeout |
| aborted | output | 1 | One-cycle pulse when an operation ends on a timeout |

## Verification
The bench stalls the target at three points: it holds it in clearing, raises busy after a chosen byte, and delays done by a chosen number of pulses. From these it builds the exact byte-and-edge log a correct master must produce, including the repeated byte during busy pulses. A design that advanced on busy would drop the repeats, and one that checked done before pulsing would show the wrong pulse count. Readback runs with zero, short and random lengths against a bus model that changes value on every rising edge. An off-by-one in sampling or in counting shows up as a shifted or missing byte, or as a missing closing pulse. Each of the three timeouts is forced, and the bench checks the status code. A start raised during a readback must not produce a program pulse.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

   typedef enum logic [1:0] {
      ST_OK       = 2'd0,
      ST_INIT_TMO = 2'd1,
      ST_BUSY_TMO = 2'd2,
      ST_DONE_TMO = 2'd3
   } pcfg_status_e;

   typedef enum logic [3:0] {
      S_IDLE, S_PROG, S_WAIT, S_ARM, S_FETCH, S_LLOW, S_LHIGH,
      S_CSOFF, S_WROFF, S_DLOW, S_DHIGH,
      S_RSEL, S_RLOW, S_RHIGH, S_REND, S_RTAIL
   } pcfg_state_e;

endpackage

// File: rtl/pcfg_phase.sv
module pcfg_phase #(
   parameter int PHASE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int CW = (PHASE > 1) ? $clog2(PHASE) : 1;
   localparam logic [CW-1:0] LAST = CW'(PHASE - 1);

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (restart || tick) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   // R5
   phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/pcfg_watch.sv
module pcfg_watch #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] TOP = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   assign expired = (cnt_q == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clear)    cnt_q <= '0;
      else if (!expired) cnt_q <= cnt_q + 1'b1;
   end

   // R3
   watch_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TOP);
endmodule

// File: rtl/pcfg_seq.sv
module pcfg_seq
   import pcfg_pkg::*;
#(
   parameter int DW         = 8,
   parameter int LEN_W      = 16,
   parameter bit BUSY_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_load_i,
   input  logic             start_dump_i,
   input  logic [LEN_W-1:0] dump_len_i,
   input  logic [DW-1:0]    ld_data_i,
   input  logic             ld_valid_i,
   input  logic             ld_last_i,
   input  logic             clearing_i,
   input  logic             busy_i,
   input  logic             done_i,
   input  logic [DW-1:0]    rd_i,
   input  logic             tick_i,
   input  logic             expired_i,
   output logic             restart_o,
   output logic             watch_clr_o,
   output logic             ld_ready_o,
   output logic [DW-1:0]    rb_data_o,
   output logic             rb_valid_o,
   output logic             prog_o,
   output logic             sel_o,
   output logic             wr_o,
   output logic             clk_o,
   output logic             drive_o,
   output logic [DW-1:0]    wdata_o,
   output logic             active_o,
   output logic             fin_o,
   output pcfg_status_e     code_o,
   output logic             abort_o
);
   pcfg_state_e  st_q, st_d;
   logic [DW-1:0]    byte_q, rbd_q;
   logic             last_q, rbv_q, fin_q, abort_q;
   logic             fin_d, abort_d, cap;
   pcfg_status_e     code_q, code_d;
   logic [LEN_W-1:0] len_q, cnt_q;
   logic             busy_chk;

   if (BUSY_CHECK) begin : g_busy
      assign busy_chk = busy_i;
   end else begin : g_nobusy
      assign busy_chk = 1'b0;
   end

   always_comb begin
      st_d    = st_q;
      fin_d   = 1'b0;
      abort_d = 1'b0;
      code_d  = ST_OK;
      cap     = 1'b0;
      case (st_q)
         S_IDLE: begin
            if (start_load_i)      st_d = S_PROG;
            else if (start_dump_i) st_d = S_RSEL;
         end
         S_PROG: if (tick_i) st_d = S_WAIT;
         S_WAIT: begin
            if (expired_i) begin
               st_d = S_IDLE; fin_d = 1'b1; abort_d = 1'b1; code_d = ST_INIT_TMO;
            end else if (tick_i && !clearing_i && !busy_i) begin
               st_d = S_ARM;
            end
         end
         S_ARM:   if (tick_i) st_d = S_FETCH;
         S_FETCH: if (ld_valid_i) st_d = S_LLOW;
         S_LLOW: begin
            if (expired_i) begin
               st_d = S_IDLE; fin_d = 1'b1; abort_d = 1'b1; code_d = ST_BUSY_TMO;
            end else if (tick_i) begin
               st_d = S_LHIGH;
            end
         end
         S_LHIGH: begin
            if (expired_i) begin
               st_d = S_IDLE; fin_d = 1'b1; abort_d = 1'b1; code_d = ST_BUSY_TMO;
            end else if (tick_i) begin
               if (busy_chk)    st_d = S_LLOW;
               else if (last_q) st_d = S_CSOFF;
               else             st_d = S_FETCH;
            end
         end
         S_CSOFF: if (tick_i) st_d = S_WROFF;
         S_WROFF: begin
            if (tick_i) begin
               if (done_i) begin
                  st_d = S_IDLE; fin_d = 1'b1;
               end else begin
                  st_d = S_DLOW;
               end
            end
         end
         S_DLOW: begin
            if (expired_i) begin
               st_d = S_IDLE; fin_d = 1'b1; abort_d = 1'b1; code_d = ST_DONE_TMO;
            end else if (tick_i) begin
               st_d = S_DHIGH;
            end
         end
         S_DHIGH: begin
            if (expired_i) begin
               st_d = S_IDLE; fin_d = 1'b1; abort_d = 1'b1; code_d = ST_DONE_TMO;
            end else if (tick_i) begin
               if (done_i) begin
                  st_d = S_IDLE; fin_d = 1'b1;
               end else begin
                  st_d = S_DLOW;
               end
            end
         end
         S_RSEL: if (tick_i) st_d = (len_q == '0) ? S_REND : S_RLOW;
         S_RLOW: if (tick_i) st_d = S_RHIGH;
         S_RHIGH: begin
            if (tick_i) begin
               cap  = 1'b1;
               st_d = ((cnt_q + 1'b1) == len_q) ? S_REND : S_RLOW;
            end
         end
         S_REND:  if (tick_i) st_d = S_RTAIL;
         S_RTAIL: begin
            if (tick_i) begin
               st_d = S_IDLE; fin_d = 1'b1;
            end
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         byte_q  <= '0;
         last_q  <= 1'b0;
         rbd_q   <= '0;
         rbv_q   <= 1'b0;
         fin_q   <= 1'b0;
         abort_q <= 1'b0;
         code_q  <= ST_OK;
         len_q   <= '0;
         cnt_q   <= '0;
      end else begin
         st_q    <= st_d;
         fin_q   <= fin_d;
         abort_q <= abort_d;
         code_q  <= code_d;
         rbv_q   <= cap;
         if (st_q == S_FETCH && ld_valid_i) begin
            byte_q <= ld_data_i;
            last_q <= ld_last_i;
         end
         if (st_q == S_IDLE && !start_load_i && start_dump_i) begin
            len_q <= dump_len_i;
            cnt_q <= '0;
         end
         if (cap) begin
            rbd_q <= rd_i;
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign restart_o   = (st_q != st_d);
   assign watch_clr_o = !(st_q inside {S_WAIT, S_LLOW, S_LHIGH, S_DLOW, S_DHIGH});
   assign ld_ready_o  = (st_q == S_FETCH);
   assign prog_o      = (st_q == S_PROG);
   assign sel_o       = st_q inside {S_ARM, S_FETCH, S_LLOW, S_LHIGH, S_RSEL, S_RLOW, S_RHIGH};
   assign wr_o        = st_q inside {S_ARM, S_FETCH, S_LLOW, S_LHIGH, S_CSOFF};
   assign clk_o       = !(st_q inside {S_LLOW, S_DLOW, S_RLOW, S_REND});
   assign drive_o     = wr_o;
   assign wdata_o     = byte_q;
   assign rb_data_o   = rbd_q;
   assign rb_valid_o  = rbv_q;
   assign active_o    = (st_q != S_IDLE);
   assign fin_o       = fin_q;
   assign code_o      = code_q;
   assign abort_o     = abort_q;

   // R4
   handshake_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid_i && ld_ready_o) |=> (!clk_o && drive_o && wdata_o == $past(ld_data_i)));

   // R8
   sel_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(wr_o) && !abort_o) |-> !$past(sel_o));

   // R10
   rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o && !wr_o) |-> !drive_o);

   // R2
   prog_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_o |-> (!sel_o && !wr_o));

   // R9
   abort_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> (fin_o && code_o != ST_OK));

   // R11
   fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |=> !fin_o);

   // R12
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && !fin_d && st_q != S_PROG && st_q != S_RSEL) |=> $past(active_o) && (st_q != S_PROG || $past(st_q) == S_PROG));
endmodule

// File: rtl/pcfg_master.sv
module pcfg_master
   import pcfg_pkg::*;
#(
   parameter int DW         = 8,
   parameter int LEN_W      = 16,
   parameter int PHASE      = 4,
   parameter int TMO_CYCLES = 2_500_000,
   parameter bit BUSY_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_load,
   input  logic             start_dump,
   input  logic [LEN_W-1:0] dump_len,
   input  logic [DW-1:0]    ld_data,
   input  logic             ld_valid,
   input  logic             ld_last,
   output logic             ld_ready,
   output logic [DW-1:0]    rb_data,
   output logic             rb_valid,
   output logic             cfg_prog,
   output logic             cfg_sel,
   output logic             cfg_wr,
   output logic             cfg_clk,
   inout  wire  [DW-1:0]    cfg_dq,
   input  logic             cfg_clearing,
   input  logic             cfg_busy,
   input  logic             cfg_done,
   output logic             active,
   output logic             fin,
   output logic [1:0]       fin_code,
   output logic             aborted
);
   if (PHASE < 1) begin : g_bad_phase
      $error("PHASE must be at least one system clock");
   end
   if (TMO_CYCLES <= 4 * PHASE) begin : g_bad_tmo
      $error("TMO_CYCLES must exceed four clock phases");
   end
   if (LEN_W < 1 || DW < 1) begin : g_bad_width
      $error("LEN_W and DW must be positive");
   end

   logic          tick, expired, restart, watch_clr, drive;
   logic [DW-1:0] wdata;
   pcfg_status_e  code;

   pcfg_phase #(.PHASE(PHASE)) u_phase (
      .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
   );

   pcfg_watch #(.LIMIT(TMO_CYCLES)) u_watch (
      .clk(clk), .rst_n(rst_n), .clear(watch_clr), .expired(expired)
   );

   pcfg_seq #(.DW(DW), .LEN_W(LEN_W), .BUSY_CHECK(BUSY_CHECK)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start_load_i(start_load), .start_dump_i(start_dump), .dump_len_i(dump_len),
      .ld_data_i(ld_data), .ld_valid_i(ld_valid), .ld_last_i(ld_last),
      .clearing_i(cfg_clearing), .busy_i(cfg_busy), .done_i(cfg_done),
      .rd_i(cfg_dq), .tick_i(tick), .expired_i(expired),
      .restart_o(restart), .watch_clr_o(watch_clr),
      .ld_ready_o(ld_ready), .rb_data_o(rb_data), .rb_valid_o(rb_valid),
      .prog_o(cfg_prog), .sel_o(cfg_sel), .wr_o(cfg_wr), .clk_o(cfg_clk),
      .drive_o(drive), .wdata_o(wdata), .active_o(active),
      .fin_o(fin), .code_o(code), .abort_o(aborted)
   );

   assign cfg_dq   = drive ? wdata : {DW{1'bz}};
   assign fin_code = code;
endmodule

// File: tb/test_pcfg_master.sv
module test_pcfg_master;
   localparam int PH  = 2;
   localparam int TMO = 200;
   localparam int LW  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          start_load = 1'b0, start_dump = 1'b0;
   logic [LW-1:0] dump_len = '0;
   logic [7:0]    ld_data = '0;
   logic          ld_valid = 1'b0, ld_last = 1'b0;
   logic          ld_ready, rb_valid, cfg_prog, cfg_sel, cfg_wr, cfg_clk;
   logic [7:0]    rb_data;
   wire  [7:0]    cfg_dq;
   logic          cfg_clearing = 1'b0, cfg_busy = 1'b0, cfg_done = 1'b0;
   logic          active, fin, aborted;
   logic [1:0]    fin_code;
   logic [7:0]    rb_drive = '0;

   assign cfg_dq = (cfg_sel && !cfg_wr) ? rb_drive : 8'hzz;

   pcfg_master #(.DW(8), .LEN_W(LW), .PHASE(PH), .TMO_CYCLES(TMO), .BUSY_CHECK(1'b1)) i_pcfg_master (
      .clk(clk), .rst_n(rst_n), .start_load(start_load), .start_dump(start_dump),
      .dump_len(dump_len), .ld_data(ld_data), .ld_valid(ld_valid), .ld_last(ld_last),
      .ld_ready(ld_ready), .rb_data(rb_data), .rb_valid(rb_valid),
      .cfg_prog(cfg_prog), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_clk(cfg_clk),
      .cfg_dq(cfg_dq), .cfg_clearing(cfg_clearing), .cfg_busy(cfg_busy), .cfg_done(cfg_done),
      .active(active), .fin(fin), .fin_code(fin_code), .aborted(aborted)
   );

   int errs = 0, checks = 0;
   int cyc = 0;
   logic [7:0] sent [0:63];
   logic [7:0] ld_log [0:63];
   logic [7:0] rb_log [0:63];
   int ld_n, rb_n, rb_edges, dclk, prog_cyc, cs_first, phase_bad, low_len;
   int busy_at, busy_extra, busy_left, done_after, pat_off, rel_cyc, cs_fall_cyc;
   bit cs_seen, fin_seen, abort_seen, wr_fall_ok;
   int fin_code_seen;
   logic clk_prev = 1'b1, cs_prev = 1'b0, wr_prev = 1'b0;

   function automatic logic [7:0] pat(int k);
      return 8'(k * 29 + pat_off);
   endfunction

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // target model and observer, sampling away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errs++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         summary();
         $finish;
      end
      if (cfg_prog) prog_cyc++;
      if (cfg_sel && !cs_prev) begin
         cs_seen = 1'b1;
         if (cs_first < 0) cs_first = cyc;
      end
      if (!cfg_sel && cs_prev && cfg_wr) cs_fall_cyc = cyc;
      if (!cfg_wr && wr_prev) wr_fall_ok = !cfg_sel && (cyc - cs_fall_cyc == PH);
      if (!cfg_clk) low_len++;
      if (cfg_clk && !clk_prev) begin
         if (cfg_sel && cfg_wr) begin
            if (low_len != PH) phase_bad++;
            if (ld_n < 64) ld_log[ld_n] = cfg_dq;
            ld_n++;
            if (cfg_busy) begin
               busy_left--;
               if (busy_left == 0) cfg_busy = 1'b0;
            end else if (ld_n == busy_at) begin
               cfg_busy = 1'b1;
               busy_left = busy_extra;
            end
         end else if (cfg_sel && !cfg_wr) begin
            rb_edges++;
            rb_drive = pat(rb_edges);
         end else if (!cfg_sel && !cfg_wr) begin
            dclk++;
            if (dclk == done_after) cfg_done = 1'b1;
         end
         low_len = 0;
      end
      if (rb_valid) begin
         if (rb_n < 64) rb_log[rb_n] = rb_data;
         rb_n++;
      end
      if (fin) begin
         fin_seen = 1'b1;
         fin_code_seen = int'(fin_code);
         abort_seen = aborted;
      end
      clk_prev = cfg_clk;
      cs_prev  = cfg_sel;
      wr_prev  = cfg_wr;
   end

   task automatic clear_mon;
      ld_n = 0; rb_n = 0; rb_edges = 0; dclk = 0; prog_cyc = 0; cs_first = -1;
      phase_bad = 0; low_len = 0; busy_left = 0; cs_seen = 0; fin_seen = 0;
      abort_seen = 0; wr_fall_ok = 0; fin_code_seen = -1; cs_fall_cyc = 0;
   endtask

   task automatic push(input logic [7:0] b, input logic l);
      ld_data = b; ld_last = l; ld_valid = 1'b1;
      while (!ld_ready) @(negedge clk);
      @(negedge clk);
      ld_valid = 1'b0; ld_last = 1'b0;
   endtask

   task automatic wait_fin;
      while (!fin_seen) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run_load(input int n, input int b_at, input int b_extra,
                           input int d_after, input int gap_max, input int hold);
      @(negedge clk);
      clear_mon();
      busy_at = b_at; busy_extra = b_extra; done_after = d_after;
      cfg_done = (d_after == 0);
      cfg_clearing = (hold > 0);
      for (int i = 0; i < n; i++) sent[i] = 8'($urandom);
      start_load = 1'b1;
      @(negedge clk);
      start_load = 1'b0;
      if (hold > 0) begin
         repeat (hold) @(negedge clk);
         rel_cyc = cyc;
         cfg_clearing = 1'b0;
      end
      for (int i = 0; i < n; i++) begin
         repeat ($urandom_range(gap_max, 0)) @(negedge clk);
         push(sent[i], i == n - 1);
      end
      wait_fin();
   endtask

   task automatic check_log(input int n, input string req);
      int e = 0;
      int bad = -1;
      int bad_act = 0, bad_exp = 0;
      for (int k = 0; k < n; k++) begin
         int reps = (k + 1 == busy_at) ? busy_extra + 1 : 1;
         for (int r = 0; r < reps; r++) begin
            if (e < 64 && bad < 0 && ld_log[e] !== sent[k]) begin
               bad = e; bad_act = int'(ld_log[e]); bad_exp = int'(sent[k]);
            end
            e++;
         end
      end
      chk(ld_n == e, {req, " edge count"}, ld_n, e);
      chk(bad < 0, {req, " byte order"}, bad_act, bad_exp);
   endtask

   task automatic run_dump(input int len, input bit poke);
      @(negedge clk);
      clear_mon();
      pat_off = int'($urandom_range(255, 0));
      done_after = 100000; cfg_done = 1'b0;
      rb_drive = pat(0);
      dump_len = LW'(len);
      start_dump = 1'b1;
      @(negedge clk);
      start_dump = 1'b0;
      if (poke) begin
         repeat (3) @(negedge clk);
         start_load = 1'b1;
         @(negedge clk);
         start_load = 1'b0;
      end
      wait_fin();
   endtask

   task automatic check_dump(input int len, input string req);
      int bad = -1;
      int bad_act = 0, bad_exp = 0;
      chk(rb_n == len, {req, " byte count"}, rb_n, len);
      for (int j = 0; j < len && j < 64; j++) begin
         if (bad < 0 && rb_log[j] !== pat(j + 1)) begin
            bad = j; bad_act = int'(rb_log[j]); bad_exp = int'(pat(j + 1));
         end
      end
      chk(bad < 0, {req, " sampled data"}, bad_act, bad_exp);
      // R11: one closing pulse while deselected, status ok
      chk(dclk == 1, "R11 closing pulse", dclk, 1);
      chk(fin_code_seen == 0 && !abort_seen, "R11 status", fin_code_seen, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      clear_mon();
      busy_at = 0; busy_extra = 0; done_after = 100000; pat_off = 0; rel_cyc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!cfg_prog && !cfg_sel && !cfg_wr && cfg_clk, "R1 pins idle",
          {cfg_prog, cfg_sel, cfg_wr, cfg_clk}, 4'b0001);
      chk(!ld_ready && !rb_valid && !fin && !aborted && !active, "R1 status idle",
          {ld_ready, rb_valid, fin, aborted, active}, 0);

      // directed load with a held clearing phase and delayed done
      run_load(4, 0, 0, 3, 2, 20);
      chk(prog_cyc == PH, "R2 program pulse length", prog_cyc, PH);
      chk(cs_first > rel_cyc, "R2 select after clearing", cs_first, rel_cyc + 1);
      check_log(4, "R4");
      chk(phase_bad == 0, "R5 low phase length", phase_bad, 0);
      chk(wr_fall_ok, "R8 select then write release", wr_fall_ok, 1);
      chk(dclk == 3, "R9 pulses until done", dclk, 3);
      chk(fin_code_seen == 0 && !abort_seen, "R9 ok status", fin_code_seen, 0);

      // single-byte load, done already high
      run_load(1, 0, 0, 0, 0, 0);
      check_log(1, "R4 single byte");
      chk(dclk == 0, "R9 done already high", dclk, 0);

      // busy stretch on the second byte
      run_load(5, 2, 3, 1, 1, 0);
      check_log(5, "R6 busy repeats");
      chk(phase_bad == 0, "R5 low phase with busy", phase_bad, 0);
      chk(fin_code_seen == 0, "R6 status", fin_code_seen, 0);

      // random loads
      for (int t = 0; t < 4; t++) begin
         int n = int'($urandom_range(10, 1));
         int d = int'($urandom_range(4, 0));
         run_load(n, 0, 0, d, 3, 0);
         check_log(n, "R4 random");
         chk(dclk == d, "R9 random done", dclk, d);
         chk(wr_fall_ok, "R8 random", wr_fall_ok, 1);
      end

      // R3 init timeout
      @(negedge clk);
      clear_mon();
      cfg_clearing = 1'b1;
      start_load = 1'b1;
      @(negedge clk);
      start_load = 1'b0;
      wait_fin();
      cfg_clearing = 1'b0;
      chk(fin_code_seen == 1 && abort_seen, "R3 init timeout code", fin_code_seen, 1);
      chk(!cs_seen, "R3 never selected", cs_seen, 0);

      // R7 busy timeout on the last byte
      run_load(3, 3, 100000, 1, 0, 0);
      cfg_busy = 1'b0;
      chk(fin_code_seen == 2 && abort_seen, "R7 busy timeout code", fin_code_seen, 2);

      // R9 done timeout
      run_load(2, 0, 0, 100000, 0, 0);
      chk(fin_code_seen == 3 && abort_seen, "R9 done timeout code", fin_code_seen, 3);

      // readback
      run_dump(5, 1'b0);
      check_dump(5, "R10");
      run_dump(0, 1'b0);
      chk(rb_n == 0, "R13 empty readback", rb_n, 0);
      chk(dclk == 1 && fin_code_seen == 0, "R13 closing pulse", dclk, 1);
      run_dump(7, 1'b1);
      check_dump(7, "R10 with start poke");
      chk(prog_cyc == 0, "R12 start ignored while active", prog_cyc, 0);
      for (int t = 0; t < 2; t++) begin
         int n = int'($urandom_range(20, 1));
         run_dump(n, 1'b0);
         check_dump(n, "R10 random");
      end

      // R12 simultaneous starts: load wins
      @(negedge clk);
      clear_mon();
      done_after = 1; cfg_done = 1'b0;
      start_load = 1'b1; start_dump = 1'b1;
      @(negedge clk);
      start_load = 1'b0; start_dump = 1'b0;
      repeat (PH + 2) @(negedge clk);
      chk(prog_cyc == PH, "R12 load priority", prog_cyc, PH);
      sent[0] = 8'h5A;
      push(8'h5A, 1'b1);
      wait_fin();
      busy_at = 0;
      check_log(1, "R12 load after tie");

      summary();
      $finish;
   end
endmodule